// File: doc/BRIEF.md
# Random Number Generator Register Peripheral

A memory-mapped random word source with a 32-bit register port. A linear feedback shift register stands in for the noise source. It is stepped at a rate set by a power-of-two divider. Each step yields one bit to a conditioning stage, which packs 32 bits into a word and pushes it into a word FIFO. Software polls a data-ready status bit or takes an interrupt, then pops words by reading the data register.

The peripheral detects two kinds of fault, both injected from pins in this model. A seed fault halts word production. A clock fault can be masked by a control bit. Each fault shows up in two status bits: one follows the fault as it happens, and one holds until software clears it. After a seed fault the FIFO keeps its old words. Software clears the held flag and drains the FIFO before production resumes.

Start-up is a two-step handshake. The first control write loads the configuration with the conditioning-reset bit set. The second write clears that bit and sets enable. Internally, the conditioning stage and the FIFO are linked by a valid/ready stream. When the FIFO is full, the stage keeps its finished word and stops taking bits until space opens. On the register side, a data read acts as the FIFO's ready.

Top module: `rng_periph`

## Requirements
- R1: The control register is at offset 0x00, status at 0x04 and data at 0x08. Control reads back the last written value masked to bits 2, 3, 5, 8..25 and 30. Any other offset reads 0. All registers read 0 after reset.
- R2: With the divider exponent d in control bits 19:16, the noise source steps once every 2^d clocks. A word is complete after 32 steps, so with d=0 no word is ready within 20 clocks of enabling, and with d=2 none within 100 clocks.
- R3: While control bit 30 (conditioning reset) is set, the FIFO and conditioning stage are held empty. Data ready rises only after a write that clears bit 30 and sets bit 2 (enable).
- R4: Status bit 0 (data ready) is 1 exactly when the FIFO holds at least one word.
- R5: Each read of offset 0x08 pops one word. Four reads in a row after a single ready check all return fresh words, and successive words differ.
- R6: Reading offset 0x08 with the FIFO empty returns 0 and changes no state.
- R7: The FIFO holds 12 words. Once it is full, production stops, and exactly 12 reads drain it.
- R8: A high seed_fault input sets status bit 2 (current) while it is high and sets status bit 6 (held). Production then stays stopped until bit 6 is cleared and the FIFO is empty.
- R9: Writing the status register clears a held flag (bit 5 or bit 6) where the written bit is 0. A written 1 leaves it unchanged.
- R10: Status bit 1 (current clock fault) equals clk_fault unless control bit 5 is set, and it sets held bit 5.
- R11: irq equals control bit 3 ANDed with the OR of status bits 0, 5 and 6.
- R12: With enable (bit 2) clear, no new words are produced, and words already in the FIFO stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access |
| seed_fault | input | 1 | Injected seed fault |
| clk_fault | input | 1 | Injected clock fault |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- the FIFO never exceeds its depth;
- irq never rises without its enable;
- conditioning reset empties the FIFO;
- the stream never pushes while production is stopped by a seed fault;
- each fault input sets its held flag;
- an empty data read returns 0.

Other behaviour needs the bench's scenarios, because it builds up over many cycles or many accesses:
- the divider timing;
- the exact count of 12 words;
- the four-read burst;
- write-0 clearing;
- restart only after both clearing and draining.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_DATA = 4'h8;

  localparam int unsigned C_EN      = 2;
  localparam int unsigned C_IE      = 3;
  localparam int unsigned C_NOCLKCHK = 5;
  localparam int unsigned C_DIV_LO  = 16;
  localparam int unsigned C_CRST    = 30;

  localparam int unsigned S_RDY     = 0;
  localparam int unsigned S_CLK_NOW = 1;
  localparam int unsigned S_SEED_NOW = 2;
  localparam int unsigned S_CLK_HELD = 5;
  localparam int unsigned S_SEED_HELD = 6;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h43FF_FF2C;
endpackage

// File: rtl/rng_noise_src.sv
module rng_noise_src #(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned LFSR_W = 32,
  parameter logic [LFSR_W-1:0] SEED = 32'hACE1_2B57,
  parameter logic [LFSR_W-1:0] TAPS = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             nbit
);
  localparam int unsigned PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  pre_mask;
  logic [LFSR_W-1:0] lfsr_q;

  assign pre_mask = ~({PRE_W{1'b1}} << div);
  assign tick     = run && ((pre_q & pre_mask) == pre_mask);
  assign nbit     = lfsr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      lfsr_q <= SEED;
    end else begin
      if (!run) pre_q <= '0;
      else      pre_q <= pre_q + 1'b1;
      if (tick) begin
        if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ TAPS;
        else           lfsr_q <= lfsr_q >> 1;
      end
    end
  end
endmodule

// File: rtl/rng_conditioner.sv
module rng_conditioner #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic              nbit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign out_valid = (cnt_q == FULL);
  assign out_data  = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (out_valid) begin
      if (out_ready) cnt_q <= '0;
    end else if (tick) begin
      sh_q  <= {sh_q[WORD_W-2:0], nbit};
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push, pop;

  assign in_ready  = (cnt_q != CNT_W'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rp_q];
  assign count     = cnt_q;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rng_periph.sv
module rng_periph #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 12,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              seed_fault,
  input  logic              clk_fault,
  output logic              irq
);
  import rng_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] ctrl_q;
  logic              en, ie, noclk, crst;
  logic [DIV_W-1:0]  div;
  logic              held_clk_q, held_seed_q, blocked_q;
  logic              clk_now, run;
  logic              wr_ctrl, wr_stat, rd_data;
  logic              tick, nbit;
  logic              st_valid, st_ready;
  logic [DATA_W-1:0] st_data;
  logic              drdy, pop;
  logic [DATA_W-1:0] fifo_data;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [DATA_W-1:0] stat;

  assign en    = ctrl_q[C_EN];
  assign ie    = ctrl_q[C_IE];
  assign noclk = ctrl_q[C_NOCLKCHK];
  assign div   = ctrl_q[C_DIV_LO +: DIV_W];
  assign crst  = ctrl_q[C_CRST];

  assign wr_ctrl = reg_en && reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = reg_en && reg_we && (reg_addr == ADDR_W'(OFF_STAT));
  assign rd_data = reg_en && !reg_we && (reg_addr == ADDR_W'(OFF_DATA));
  assign pop     = rd_data && drdy;

  assign clk_now = clk_fault && !noclk;
  assign run     = en && !crst && !blocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      held_clk_q  <= 1'b0;
      held_seed_q <= 1'b0;
      blocked_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
      held_clk_q  <= clk_now ||
                     (held_clk_q && !(wr_stat && !reg_wdata[S_CLK_HELD]));
      held_seed_q <= seed_fault ||
                     (held_seed_q && !(wr_stat && !reg_wdata[S_SEED_HELD]));
      blocked_q   <= seed_fault || (blocked_q && (held_seed_q || drdy));
    end
  end

  rng_noise_src #(.DIV_W(DIV_W), .LFSR_W(DATA_W)) u_noise (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (div),
    .tick (tick),
    .nbit (nbit)
  );

  rng_conditioner #(.WORD_W(DATA_W)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!run),
    .tick     (tick),
    .nbit     (nbit),
    .out_valid(st_valid),
    .out_ready(st_ready),
    .out_data (st_data)
  );

  rng_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (crst),
    .in_valid (st_valid),
    .in_ready (st_ready),
    .in_data  (st_data),
    .out_valid(drdy),
    .out_ready(pop),
    .out_data (fifo_data),
    .count    (fifo_cnt)
  );

  always_comb begin
    stat = '0;
    stat[S_RDY]       = drdy;
    stat[S_CLK_NOW]   = clk_now;
    stat[S_SEED_NOW]  = seed_fault;
    stat[S_CLK_HELD]  = held_clk_q;
    stat[S_SEED_HELD] = held_seed_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_we) begin
      case (reg_addr)
        ADDR_W'(OFF_CTRL): reg_rdata = ctrl_q;
        ADDR_W'(OFF_STAT): reg_rdata = stat;
        ADDR_W'(OFF_DATA): reg_rdata = drdy ? fifo_data : '0;
        default:           reg_rdata = '0;
      endcase
    end
  end

  assign irq = ie && (drdy || held_clk_q || held_seed_q);
endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ie,
  input logic             crst,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             st_valid,
  input logic             st_ready,
  input logic             blocked_q,
  input logic             seed_fault,
  input logic             held_seed_q,
  input logic             clk_now,
  input logic             held_clk_q,
  input logic             rd_data,
  input logic [31:0]      reg_rdata
);
  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);

  assert_crst_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crst |=> (fifo_cnt == '0));

  assert_no_push_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |-> !(st_valid && st_ready));

  assert_seed_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_fault |=> held_seed_q);

  assert_clk_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_now |=> held_clk_q);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && fifo_cnt == '0) |-> (reg_rdata == '0));
endmodule

bind rng_periph rng_periph_chk #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .ie         (ie),
  .crst       (crst),
  .fifo_cnt   (fifo_cnt),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .blocked_q  (blocked_q),
  .seed_fault (seed_fault),
  .held_seed_q(held_seed_q),
  .clk_now    (clk_now),
  .held_clk_q (held_clk_q),
  .rd_data    (rd_data),
  .reg_rdata  (reg_rdata)
);

// File: tb/rng_periph_bench.sv
module rng_periph_bench;
  localparam logic [31:0] EN   = 32'h0000_0004;
  localparam logic [31:0] IE   = 32'h0000_0008;
  localparam logic [31:0] NOCK = 32'h0000_0020;
  localparam logic [31:0] CRST = 32'h4000_0000;
  localparam logic [31:0] DIV2 = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        seed_fault = 1'b0, clk_fault = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rng_periph u_rng_periph (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seed_fault(seed_fault), .clk_fault(clk_fault), .irq(irq)
  );

  function automatic logic [31:0] exp_ctrl(logic [31:0] v);
    return v & 32'h43FF_FF2C;
  endfunction

  function automatic logic [31:0] exp_irq(logic [31:0] ctrl, logic [31:0] st);
    return {31'b0, ctrl[3] & (st[0] | st[5] | st[6])};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] r, prev, v, ctrl;
    int n;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(4'h0, r); chk("R1 ctrl reset", r, 32'h0);
    rd(4'h4, r); chk("R4 status reset", r, 32'h0);
    chk("R11 irq reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 16; i++) begin
      logic [3:0] a;
      v = ($urandom() | CRST) & ~EN;
      wr(4'h0, v);
      rd(4'h0, r); chk("R1 ctrl readback", r, exp_ctrl(v));
      a = 4'($urandom_range(15, 0));
      if (a == 4'h0 || a == 4'h4 || a == 4'h8) a = 4'hC;
      rd(a, r); chk("R1 unmapped read", r, 32'h0);
    end

    wr(4'h0, CRST | NOCK);
    repeat (60) @(negedge clk);
    rd(4'h4, r); chk("R3 no ready in reset", r & 32'h1, 32'h0);

    ctrl = EN | NOCK;
    wr(4'h0, ctrl);
    repeat (20) @(negedge clk);
    rd(4'h4, r); chk("R2 d=0 early", r & 32'h1, 32'h0);
    repeat (25) @(negedge clk);
    rd(4'h4, r); chk("R3 ready after start", r & 32'h1, 32'h1);

    repeat (500) @(negedge clk);
    ctrl = NOCK;
    wr(4'h0, ctrl);
    prev = 32'h0;
    for (int g = 0; g < 3; g++) begin
      rd(4'h4, r); chk("R4 ready before burst", r & 32'h1, 32'h1);
      for (int k = 0; k < 4; k++) begin
        rd(4'h8, v);
        if (g != 0 || k != 0) chk("R5 fresh word", {31'b0, v != prev}, 32'h1);
        prev = v;
      end
    end
    rd(4'h4, r); chk("R7 empty after 12 reads", r & 32'h1, 32'h0);
    rd(4'h8, r); chk("R6 empty read zero", r, 32'h0);
    rd(4'h4, r); chk("R6 still empty", r & 32'h1, 32'h0);
    repeat (100) @(negedge clk);
    rd(4'h4, r); chk("R12 disabled no fill", r & 32'h1, 32'h0);

    wr(4'h0, CRST | NOCK | DIV2);
    ctrl = EN | NOCK | DIV2;
    wr(4'h0, ctrl);
    repeat (100) @(negedge clk);
    rd(4'h4, r); chk("R2 d=2 early", r & 32'h1, 32'h0);
    repeat (60) @(negedge clk);
    rd(4'h4, r); chk("R2 d=2 ready", r & 32'h1, 32'h1);

    repeat (300) @(negedge clk);
    seed_fault = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'h4, r); chk("R8 seed bits set", r & 32'h67, 32'h45);
    seed_fault = 1'b0;
    rd(4'h4, r); chk("R8 seed held only", r & 32'h67, 32'h41);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      rd(4'h4, r);
      if (r[0] == 1'b0) break;
      rd(4'h8, v);
      n++;
    end
    chk("R12 stale words kept", {31'b0, n >= 1}, 32'h1);
    repeat (200) @(negedge clk);
    rd(4'h4, r); chk("R8 stays stopped", r & 32'h41, 32'h40);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    ctrl = EN | NOCK | IE | DIV2;
    wr(4'h0, ctrl);
    rd(4'h4, r); chk("R11 irq seed held", {31'b0, irq}, exp_irq(ctrl, r));
    wr(4'h4, 32'h0000_0040);
    rd(4'h4, r); chk("R9 write one keeps", r & 32'h40, 32'h40);
    wr(4'h4, 32'h0);
    rd(4'h4, r); chk("R9 write zero clears", r & 32'h41, 32'h0);
    chk("R11 irq idle", {31'b0, irq}, exp_irq(ctrl, r));
    repeat (160) @(negedge clk);
    rd(4'h4, r); chk("R8 resumes", r & 32'h1, 32'h1);
    chk("R11 irq ready", {31'b0, irq}, exp_irq(ctrl, r));

    clk_fault = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'h4, r); chk("R10 masked", r & 32'h22, 32'h0);
    ctrl = EN | IE | DIV2;
    wr(4'h0, ctrl);
    rd(4'h4, r); chk("R10 clk fault seen", r & 32'h22, 32'h22);
    clk_fault = 1'b0;
    rd(4'h4, r); chk("R10 held only", r & 32'h22, 32'h20);
    wr(4'h4, 32'h0000_0020);
    rd(4'h4, r); chk("R9 clk held kept", r & 32'h20, 32'h20);
    wr(4'h4, 32'h0);
    rd(4'h4, r); chk("R9 clk held cleared", r & 32'h20, 32'h0);
    chk("R11 irq after clear", {31'b0, irq}, exp_irq(ctrl, r));

    done = 1;
    summary();
  end
endmodule